// File: doc/BRIEF.md
# Configurable UART frame receiver

This block decodes asynchronous serial frames arriving on one line that rests high. The line is taken directly on every rising edge of the system clock. A falling transition marks the start of a frame. From that instant the block works out where the centre of every bit lies. It does this with a fractional phase accumulator, so a bit period that is not a whole number of clocks does not drift over the frame. Each bit is taken once, at its centre, measured from the frame start alone. There is no realignment on later edges.

The data width (5 to 9 bits), the bit order and the parity mode are run-time inputs. The block captures them at the start edge, so a frame is always decoded with one consistent setting. When the stop bit has been sampled, the block presents the received word with a one-clock valid strobe. Three error flags come with that strobe: bad start bit, parity mismatch and bad stop bit. An error never cuts a frame short. To decode two directions of a link, place two instances, one on each line.

Top module: `uart_frame_rx`

## Requirements
- R1: During and right after synchronous reset, `rx_valid`, `err_start`, `err_parity` and `err_stop` are 0, `rx_word` is 0, and the stored previous line level is 1.
- R2: A frame starts only on a clock where the line is 0 and was 1 on the previous clock. A line held high, or held low, starts no frame and produces no strobe.
- R3: Let e be the clock on which the start edge is seen. Bit k of the frame (k=0 is the start bit) is sampled on the first clock e+c for which 2·BAUD·c ≥ (2k+1)·CLK_HZ. The strobe for a frame is high on the clock after the stop bit is sampled.
- R4: The data width is taken from `cfg_width`, valid range 5 to 9. `rx_word` carries the word in bits [N-1:0] and zeros above bit N-1.
- R5: When `cfg_msb_first`=0, the first data bit on the line lands in `rx_word[0]`. When `cfg_msb_first`=1, it lands in `rx_word[N-1]`.
- R6: The `cfg_parity` codes are 0 none, 1 odd, 2 even, 3 always-zero and 4 always-one; codes 5 to 7 act as none. For odd or even, `err_parity` is set when the count of ones over the data bits plus the parity bit is even or odd, respectively. For always-zero, `err_parity` is set when the parity bit is 1. For always-one, it is set when the parity bit is 0.
- R7: With parity none, the stop bit is frame bit N+1. With any other parity mode, it is frame bit N+2 and the parity bit is frame bit N+1.
- R8: If the start bit reads 1 at its centre, `err_start` is set with the strobe. The data, parity and stop bits are still received on the normal schedule.
- R9: If the stop bit reads 0, `err_stop` is set with the strobe. The receiver then waits for a new 1-to-0 transition, so a line that stays low produces no second frame.
- R10: `cfg_width`, `cfg_msb_first` and `cfg_parity` are captured on the start-edge clock. Changes to them during a frame have no effect on that frame.
- R11: `rx_valid` is high for exactly one clock per frame. The error flags are 0 whenever `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial line, already synchronised to clk, high when idle |
| cfg_width | input | 4 | Data bits per frame, 5 to 9 |
| cfg_msb_first | input | 1 | 1: most significant bit first; 0: least significant bit first |
| cfg_parity | input | 3 | Parity mode code, see R6 |
| rx_word | output | 9 | Received word, updated with the strobe |
| rx_valid | output | 1 | One-clock strobe marking a finished frame |
| err_start | output | 1 | Start bit read 1 at its centre |
| err_parity | output | 1 | Parity bit did not match the selected mode |
| err_stop | output | 1 | Stop bit read 0 at its centre |

## Verification
The assertions assume the line input is already synchronous to the clock and that the configuration codes lie in the stated ranges. They also assume the clock rate is at least twice the baud rate, so the phase accumulator never needs two samples in one clock.

The bench respects all three assumptions. It drives the line only on falling clock edges, uses widths 5 to 9 and parity codes 0 to 4, and runs at 1000 clocks per 70 baud, a fractional period of about 14.3 clocks. Bit boundaries are placed at floor(k·CLK_HZ/BAUD) clocks after the start edge, so the design's sample points fall well inside each bit. This also exercises the accumulator's fractional stepping over full-length frames.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200,
  parameter int WMAX   = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_line,
  input  logic [3:0]      cfg_width,
  input  logic            cfg_msb_first,
  input  logic [2:0]      cfg_parity,
  output logic [WMAX-1:0] rx_word,
  output logic            rx_valid,
  output logic            err_start,
  output logic            err_parity,
  output logic            err_stop
);

  localparam int AW = $clog2(2*CLK_HZ + 2*BAUD + 1) + 2;
  localparam logic signed [AW-1:0] STEP_UP = AW'(2*BAUD);
  localparam logic signed [AW-1:0] STEP_DN = AW'(2*CLK_HZ);
  localparam logic signed [AW-1:0] FIRST   = AW'(2*BAUD - CLK_HZ);
  localparam int CW = $clog2(WMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                   st_q;
  logic signed [AW-1:0]  acc_q;
  logic                  prev_q;
  logic [CW-1:0]         nbits_q, cnt_q;
  logic                  msb_q;
  logic [2:0]            par_q;
  logic [WMAX-1:0]       sh_q, sh_next;
  logic                  bad_start_q, bad_par_q;
  logic [CW-1:0]         width_clamped;
  logic [2:0]            par_clean;
  logic                  par_good;

  wire at_centre = ~acc_q[AW-1];
  wire fall      = prev_q & ~rx_line;

  always_comb begin
    if (cfg_width < 4'd5)            width_clamped = CW'(5);
    else if (cfg_width > 4'(WMAX))   width_clamped = CW'(WMAX);
    else                             width_clamped = CW'(cfg_width);
  end

  assign par_clean = (cfg_parity > 3'd4) ? 3'd0 : cfg_parity;

  always_comb begin
    if (msb_q) sh_next = {sh_q[WMAX-2:0], rx_line};
    else       sh_next = {1'b0, sh_q[WMAX-1:1]} | (WMAX'(rx_line) << (nbits_q - CW'(1)));
  end

  always_comb begin
    case (par_q)
      3'd1:    par_good = (^sh_q ^ rx_line) == 1'b1;
      3'd2:    par_good = (^sh_q ^ rx_line) == 1'b0;
      3'd3:    par_good = ~rx_line;
      3'd4:    par_good = rx_line;
      default: par_good = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      acc_q       <= '0;
      prev_q      <= 1'b1;
      nbits_q     <= CW'(8);
      cnt_q       <= '0;
      msb_q       <= 1'b0;
      par_q       <= 3'd0;
      sh_q        <= '0;
      bad_start_q <= 1'b0;
      bad_par_q   <= 1'b0;
      rx_word     <= '0;
      rx_valid    <= 1'b0;
      err_start   <= 1'b0;
      err_parity  <= 1'b0;
      err_stop    <= 1'b0;
    end else begin
      prev_q     <= rx_line;
      rx_valid   <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
      if (st_q != S_IDLE)
        acc_q <= at_centre ? acc_q + STEP_UP - STEP_DN : acc_q + STEP_UP;
      case (st_q)
        S_IDLE: if (fall) begin
          st_q        <= S_START;
          acc_q       <= FIRST;
          nbits_q     <= width_clamped;
          msb_q       <= cfg_msb_first;
          par_q       <= par_clean;
          cnt_q       <= '0;
          sh_q        <= '0;
          bad_start_q <= 1'b0;
          bad_par_q   <= 1'b0;
        end
        S_START: if (at_centre) begin
          bad_start_q <= rx_line;
          st_q        <= S_DATA;
        end
        S_DATA: if (at_centre) begin
          sh_q <= sh_next;
          if (cnt_q == nbits_q - CW'(1))
            st_q <= (par_q == 3'd0) ? S_STOP : S_PAR;
          else
            cnt_q <= cnt_q + CW'(1);
        end
        S_PAR: if (at_centre) begin
          bad_par_q <= ~par_good;
          st_q      <= S_STOP;
        end
        S_STOP: if (at_centre) begin
          rx_word    <= sh_q;
          rx_valid   <= 1'b1;
          err_start  <= bad_start_q;
          err_parity <= bad_par_q;
          err_stop   <= ~rx_line;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rx_valid && !err_start && !err_parity && !err_stop && rx_word == '0); // R1
  AST_START_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst) (st_q == S_START && $past(st_q) == S_IDLE) |-> ($past(prev_q) && !$past(rx_line))); // R2
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) rx_valid |-> ((rx_word >> nbits_q) == '0)); // R4
  AST_PARITY_STATE_USED: assert property (@(posedge clk) disable iff (rst) (st_q == S_PAR) |-> (par_q != 3'd0)); // R7
  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (rst) rx_valid |-> (st_q == S_IDLE)); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) (st_q != S_IDLE && $past(st_q) != S_IDLE) |-> ($stable(nbits_q) && $stable(msb_q) && $stable(par_q))); // R10
  AST_ONE_CLOCK_STROBE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R11
  AST_FLAGS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst) (err_start || err_parity || err_stop) |-> rx_valid); // R11

endmodule

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;
  localparam int CLK_HZ = 1000;
  localparam int BAUD   = 70;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic [3:0] cfg_width = 4'd8;
  logic       cfg_msb_first = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic [8:0] rx_word;
  logic       rx_valid, err_start, err_parity, err_stop;

  uart_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .WMAX(9)) i_uart_frame_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_width(cfg_width),
    .cfg_msb_first(cfg_msb_first), .cfg_parity(cfg_parity), .rx_word(rx_word),
    .rx_valid(rx_valid), .err_start(err_start), .err_parity(err_parity), .err_stop(err_stop));

  always #5 clk = ~clk;

  int cyc = 0;
  int vectors = 0;
  int fails = 0;
  int v_cnt = 0;
  int v_cyc = 0;
  int flag_leak = 0;
  logic [8:0] v_word;
  logic v_es, v_ep, v_est;
  int e_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      v_cnt  <= v_cnt + 1;
      v_cyc  <= cyc;
      v_word <= rx_word;
      v_es   <= err_start;
      v_ep   <= err_parity;
      v_est  <= err_stop;
    end else if (err_start || err_parity || err_stop) begin
      flag_leak <= flag_leak + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [8:0] data, input int n, input bit msb, input int par,
                           input bit flip_par, input bit start_hi, input bit stop_lo,
                           input bit stay_low, input bit scramble, input string tag);
    logic fr [0:11];
    logic p;
    logic [8:0] mask;
    int len, s, c, base;
    mask = 9'((1 << n) - 1);
    cfg_width = 4'(n); cfg_msb_first = msb; cfg_parity = 3'(par);
    fr[0] = 1'b0;
    for (int i = 0; i < n; i++) fr[1+i] = msb ? data[n-1-i] : data[i];
    len = n + 2 + ((par != 0) ? 1 : 0);
    if (par != 0) begin
      case (par)
        1: p = ~^(data & mask);
        2: p = ^(data & mask);
        3: p = 1'b0;
        default: p = 1'b1;
      endcase
      fr[n+1] = p ^ flip_par;
    end
    fr[len-1] = ~stop_lo;
    base = v_cnt;
    @(negedge clk);
    rx_line = 1'b0;
    e_cyc = cyc + 1;
    if (start_hi) begin
      @(negedge clk); @(negedge clk);
      rx_line = 1'b1;
    end
    for (int k = 1; k <= len; k++) begin
      while (cyc + 1 < e_cyc + (k * CLK_HZ) / BAUD) @(negedge clk);
      rx_line = (k < len) ? fr[k] : (stay_low ? 1'b0 : 1'b1);
      if (scramble && k == 1) begin
        cfg_width = 4'(n == 5 ? 9 : 5); cfg_msb_first = ~msb; cfg_parity = 3'(par == 0 ? 4 : 0);
      end
    end
    repeat (4) @(negedge clk);
    s = len - 1;
    c = ((2*s + 1) * CLK_HZ + 2*BAUD - 1) / (2*BAUD);
    chk({tag, " R11 strobe count"}, v_cnt - base, 1);
    chk({tag, " R3 R7 strobe timing"}, v_cyc - e_cyc, c + 0);
    chk({tag, " R4 R5 word"}, int'(v_word), int'(data & mask));
    chk({tag, " R8 err_start"}, int'(v_es), int'(start_hi));
    chk({tag, " R6 err_parity"}, int'(v_ep), int'(flip_par && par != 0));
    chk({tag, " R9 err_stop"}, int'(v_est), int'(stop_lo));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid in reset", int'(rx_valid), 0);
    chk("R1 word in reset", int'(rx_word), 0);
    chk("R1 flags in reset", int'({err_start, err_parity, err_stop}), 0);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    chk("R2 high line gives no frame", v_cnt, 0);
    chk("R1 word after reset", int'(rx_word), 0);
  endtask

  task automatic t_basic_lsb;
    run_frame(9'h0A5, 8, 1'b0, 0, 0, 0, 0, 0, 0, "lsb8 none");
    run_frame(9'h03C, 8, 1'b0, 0, 0, 0, 0, 0, 0, "lsb8 none b");
  endtask

  task automatic t_msb_order;
    run_frame(9'h0B1, 8, 1'b1, 0, 0, 0, 0, 0, 0, "msb8 R5");
    run_frame(9'h053, 7, 1'b1, 2, 0, 0, 0, 0, 0, "msb7 even R5");
  endtask

  task automatic t_widths;
    run_frame(9'h015, 5, 1'b0, 1, 0, 0, 0, 0, 0, "w5 odd R4");
    run_frame(9'h1A7, 9, 1'b0, 2, 0, 0, 0, 0, 0, "w9 even R4");
    run_frame(9'h1FF, 9, 1'b1, 0, 0, 0, 0, 0, 0, "w9 msb R4");
  endtask

  task automatic t_parity;
    for (int m = 1; m <= 4; m++) begin
      run_frame(9'h06E, 8, 1'b0, m, 0, 0, 0, 0, 0, "parity good R6");
      run_frame(9'h06E, 8, 1'b0, m, 1, 0, 0, 0, 0, "parity bad R6");
    end
  endtask

  task automatic t_bad_start;
    run_frame(9'h0C3, 8, 1'b0, 1, 0, 1, 0, 0, 0, "bad start R8");
  endtask

  task automatic t_bad_stop;
    int base;
    run_frame(9'h055, 8, 1'b0, 0, 0, 0, 1, 1, 0, "bad stop R9");
    base = v_cnt;
    repeat (200) @(negedge clk);
    chk("R9 R2 low line gives no second frame", v_cnt - base, 0);
    rx_line = 1'b1;
    repeat (20) @(negedge clk);
    run_frame(9'h02D, 6, 1'b1, 3, 0, 0, 0, 0, 0, "after break R9");
  endtask

  task automatic t_cfg_freeze;
    run_frame(9'h0E4, 8, 1'b0, 1, 0, 0, 0, 0, 1, "cfg change R10");
    run_frame(9'h011, 5, 1'b1, 0, 0, 0, 0, 0, 1, "cfg change b R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_basic_lsb;
    t_msb_order;
    t_widths;
    t_parity;
    t_bad_start;
    t_bad_stop;
    t_cfg_freeze;
    chk("R11 flags only with strobe", flag_leak, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule